// File: doc/BRIEF.md
# Prescaled Timer and Watchdog Unit

This block is a small timing unit with one shared prescaler. The prescaler divides a stream of source events into ticks. Those ticks advance two general-purpose down-counters and one watchdog counter. By default the source events are the system clock cycles. Software can instead select the rising edges of an external timer clock, which the block brings into the system clock domain through two flip-flops.

Each general-purpose timer holds a reload value and a count. On underflow it sets an interrupt flag and then either reloads or stops. If its trigger is enabled, it also drives a fixed-length pulse on its own trigger output. The watchdog runs from reset. Software restarts it by writing a new reload value. If it counts out, it pulls an active-low output low and holds it there until the next restart.

Software reaches the registers through a simple one-cycle write port and a combinational read port. Both ports use 4-bit word addresses.

Top module: `tickTimerUnit`

## Requirements
- R1: After reset, irq and trigOut are 0 and wdogN is 1. The registers read 0 at address 0 (prescaler reload), at addresses 2, 3 and 4 (timer 0 reload, count and control), at addresses 5, 6 and 7 (timer 1) and at address 10 (clock select).
- R2: The prescaler count decrements on each source event. A source event with the count at 0 makes one tick and reloads the count from the reload register. Writing address 0 sets the reload value, restarts the count at that value and suppresses any tick in that cycle. With reload P, ticks come every P+1 events.
- R3: Timer control bits are: bit0 enable, bit1 auto-reload, bit2 load (a strobe, reads 0), bit3 trigger enable and bit4 interrupt flag. Writing the control register with bit2 set copies the reload value into the count. An enabled timer decrements its count by one on each tick and holds it otherwise.
- R4: A tick that finds an enabled timer at count 0 is an underflow. It sets the flag (control bit4), which drives irq[i]. With auto-reload the count reloads; without it the count stays 0 and enable clears. With the timer loaded with N, the underflow lands (N+1)(P+1) system cycles after the prescaler reload is written.
- R5: A control write with bit4 set clears the interrupt flag. A simultaneous underflow wins over the clear.
- R6: An underflow with trigger enable set drives trigOut[i] high for exactly 8 system clock cycles, starting in the cycle after the underflow edge.
- R7: A new trigger that fires while a pulse is still running restarts the 8-cycle count, so trigOut stays high for 8 cycles after the last firing.
- R8: The watchdog starts counting from WDOG_INIT at reset and decrements on each tick. A tick that finds it at 0 sets it expired. Expiry drives wdogN low, and wdogN stays low until the next restart.
- R9: Writing address 8 loads both the watchdog reload value and its count, and clears the expired state. wdogN is 1 after that write.
- R10: Bit0 of address 10 selects the external clock. When it is set, only rising edges of extClk are source events, after a two-flip-flop synchroniser plus an edge detector (3 cycles of latency). System clock cycles then advance nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClk | input | 1 | External timer clock, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 32 | Register read data (combinational) |
| irq | output | 2 | Per-timer interrupt flag |
| trigOut | output | 2 | Per-timer trigger pulse, active high |
| wdogN | output | 1 | Watchdog expired, active low |

## Verification
A prescaler count held at the wrong value shifts every underflow. Because timers are loaded just before a prescaler restart, the shift shows on irq within one timer period, at an edge the bench can predict to the cycle. A pulse counter with the wrong length or a missed restart shows at trigOut exactly 8 cycles after the last firing. A watchdog count that is off shows as wdogN falling one tick early or late. Reading the count back through the register port exposes a timer that moves without ticks, for example on system clock cycles while the external source is selected.

// File: rtl/tickTimerPkg.sv
package tickTimerPkg;
  localparam int NUM_TMR    = 2;
  localparam int ADDR_W     = 4;
  localparam int CTRL_W     = 5;

  localparam int A_PRES_RELOAD = 0;
  localparam int A_PRES_COUNT  = 1;
  localparam int A_TMR_BASE    = 2;
  localparam int TMR_STRIDE    = 3;
  localparam int OFF_RELOAD    = 0;
  localparam int OFF_COUNT     = 1;
  localparam int OFF_CTRL      = 2;
  localparam int A_WDOG_RELOAD = A_TMR_BASE + TMR_STRIDE * NUM_TMR;
  localparam int A_WDOG_COUNT  = A_WDOG_RELOAD + 1;
  localparam int A_CLK_SEL     = A_WDOG_RELOAD + 2;

  localparam int BIT_EN   = 0;
  localparam int BIT_AUTO = 1;
  localparam int BIT_LOAD = 2;
  localparam int BIT_TRIG = 3;
  localparam int BIT_IRQ  = 4;

  typedef struct packed {
    logic               tick;
    logic               presWr;
    logic [NUM_TMR-1:0] reloadWr;
    logic [NUM_TMR-1:0] ctrlWr;
    logic               wdogWr;
  } strobeT;
endpackage

// File: rtl/tickCtrl.sv
module tickCtrl
  import tickTimerPkg::*;
#(
  parameter int PRES_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PRES_W-1:0] wrData,
  output strobeT            strobes,
  output logic [PRES_W-1:0] presReload,
  output logic [PRES_W-1:0] presCount,
  output logic              extSel
);
  logic [2:0] extSync;
  logic       extEdge;
  logic       srcEvent;
  logic       presWr;
  logic       tick;

  // two-stage synchroniser plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], extClk};
  end
  assign extEdge  = extSync[1] & ~extSync[2];
  assign srcEvent = extSel ? extEdge : 1'b1;

  assign presWr = wrEn && (wrAddr == ADDR_W'(A_PRES_RELOAD));
  assign tick   = srcEvent && (presCount == '0) && !presWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presReload <= '0;
      presCount  <= '0;
    end else if (presWr) begin
      presReload <= wrData;
      presCount  <= wrData;
    end else if (srcEvent) begin
      presCount <= (presCount == '0) ? presReload : presCount - PRES_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) extSel <= 1'b0;
    else if (wrEn && wrAddr == ADDR_W'(A_CLK_SEL)) extSel <= wrData[0];
  end

  always_comb begin
    strobes.tick   = tick;
    strobes.presWr = presWr;
    strobes.wdogWr = wrEn && (wrAddr == ADDR_W'(A_WDOG_RELOAD));
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
    assign strobes.reloadWr[i] = wrEn &&
      (wrAddr == ADDR_W'(A_TMR_BASE + TMR_STRIDE * i + OFF_RELOAD));
    assign strobes.ctrlWr[i] = wrEn &&
      (wrAddr == ADDR_W'(A_TMR_BASE + TMR_STRIDE * i + OFF_CTRL));
  end

  // R2: after a tick the count restarts from the reload value
  assert_pres_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !presWr) |=> (presCount == $past(presReload)));

  // R10: with the external source selected, no event means no count change
  assert_ext_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (extSel && !extEdge && !presWr) |=> $stable(presCount));
endmodule

// File: rtl/tickTimerChannel.sv
module tickTimerChannel
  import tickTimerPkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              reloadWr,
  input  logic              ctrlWr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [CNT_W-1:0]  countVal,
  output logic [CTRL_W-1:0] ctrlVal,
  output logic              irq,
  output logic              trigOut
);
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);

  logic               enable, autoRel, trigEn, irqFlag;
  logic               loadNow, underflow, fire;
  logic [PULSE_W-1:0] pulseCnt;

  assign loadNow   = ctrlWr && wrData[BIT_LOAD];
  assign underflow = tick && enable && (countVal == '0) && !loadNow;
  assign fire      = underflow && trigEn;

  always_ff @(posedge clk) begin
    if (!rstN) reloadVal <= '0;
    else if (reloadWr) reloadVal <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (loadNow) begin
      countVal <= reloadVal;
    end else if (tick && enable) begin
      if (countVal == '0) countVal <= autoRel ? reloadVal : '0;
      else                countVal <= countVal - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      autoRel <= 1'b0;
      trigEn  <= 1'b0;
    end else if (ctrlWr) begin
      enable  <= wrData[BIT_EN];
      autoRel <= wrData[BIT_AUTO];
      trigEn  <= wrData[BIT_TRIG];
    end else if (underflow && !autoRel) begin
      enable <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              irqFlag <= 1'b0;
    else if (underflow)                     irqFlag <= 1'b1;
    else if (ctrlWr && wrData[BIT_IRQ])     irqFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 pulseCnt <= '0;
    else if (fire)             pulseCnt <= PULSE_W'(PULSE_LEN);
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - PULSE_W'(1);
  end

  assign irq     = irqFlag;
  assign trigOut = (pulseCnt != '0);

  always_comb begin
    ctrlVal           = '0;
    ctrlVal[BIT_EN]   = enable;
    ctrlVal[BIT_AUTO] = autoRel;
    ctrlVal[BIT_TRIG] = trigEn;
    ctrlVal[BIT_IRQ]  = irqFlag;
  end

  // R3: without a tick or a load the count does not move
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !loadNow) |=> $stable(countVal));

  // R4: an underflow raises the interrupt output on the next cycle
  assert_underflow_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && enable && countVal == '0 && !loadNow) |=> irq);

  // R6: a trigger pulse is never a single cycle
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |=> trigOut);
endmodule

// File: rtl/tickDatapath.sv
module tickDatapath
  import tickTimerPkg::*;
#(
  parameter int               CNT_W     = 32,
  parameter int               PULSE_LEN = 8,
  parameter logic [CNT_W-1:0] WDOG_INIT = 32'h0000_FFFF
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobeT                         strobes,
  input  logic [CNT_W-1:0]               wrData,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  tmrReload,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  tmrCount,
  output logic [NUM_TMR-1:0][CTRL_W-1:0] tmrCtrl,
  output logic [NUM_TMR-1:0]             irq,
  output logic [NUM_TMR-1:0]             trigOut,
  output logic [CNT_W-1:0]               wdogReload,
  output logic [CNT_W-1:0]               wdogCount,
  output logic                           wdogN
);
  logic expired;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    tickTimerChannel #(
      .CNT_W     (CNT_W),
      .PULSE_LEN (PULSE_LEN)
    ) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .tick      (strobes.tick),
      .reloadWr  (strobes.reloadWr[i]),
      .ctrlWr    (strobes.ctrlWr[i]),
      .wrData    (wrData),
      .reloadVal (tmrReload[i]),
      .countVal  (tmrCount[i]),
      .ctrlVal   (tmrCtrl[i]),
      .irq       (irq[i]),
      .trigOut   (trigOut[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdogReload <= WDOG_INIT;
      wdogCount  <= WDOG_INIT;
      expired    <= 1'b0;
    end else if (strobes.wdogWr) begin
      wdogReload <= wrData;
      wdogCount  <= wrData;
      expired    <= 1'b0;
    end else if (strobes.tick && !expired) begin
      if (wdogCount == '0) expired   <= 1'b1;
      else                 wdogCount <= wdogCount - CNT_W'(1);
    end
  end

  assign wdogN = !expired;

  // R8: once low, the watchdog output stays low until a restart
  assert_wdog_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!wdogN && !strobes.wdogWr) |=> !wdogN);

  // R9: a restart always releases the watchdog output
  assert_wdog_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wdogWr |=> wdogN);
endmodule

// File: rtl/tickTimerUnit.sv
module tickTimerUnit
  import tickTimerPkg::*;
#(
  parameter int               PRES_W    = 10,
  parameter int               CNT_W     = 32,
  parameter int               PULSE_LEN = 8,
  parameter logic [CNT_W-1:0] WDOG_INIT = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_TMR-1:0] irq,
  output logic [NUM_TMR-1:0] trigOut,
  output logic              wdogN
);
  strobeT                         strobes;
  logic [PRES_W-1:0]              presReload, presCount;
  logic                           extSel;
  logic [NUM_TMR-1:0][CNT_W-1:0]  tmrReload, tmrCount;
  logic [NUM_TMR-1:0][CTRL_W-1:0] tmrCtrl;
  logic [CNT_W-1:0]               wdogReload, wdogCount;

  tickCtrl #(.PRES_W(PRES_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .extClk     (extClk),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData[PRES_W-1:0]),
    .strobes    (strobes),
    .presReload (presReload),
    .presCount  (presCount),
    .extSel     (extSel)
  );

  tickDatapath #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN),
    .WDOG_INIT (WDOG_INIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .tmrReload  (tmrReload),
    .tmrCount   (tmrCount),
    .tmrCtrl    (tmrCtrl),
    .irq        (irq),
    .trigOut    (trigOut),
    .wdogReload (wdogReload),
    .wdogCount  (wdogCount),
    .wdogN      (wdogN)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(A_PRES_RELOAD)) rdData = CNT_W'(presReload);
    if (rdAddr == ADDR_W'(A_PRES_COUNT))  rdData = CNT_W'(presCount);
    if (rdAddr == ADDR_W'(A_WDOG_RELOAD)) rdData = wdogReload;
    if (rdAddr == ADDR_W'(A_WDOG_COUNT))  rdData = wdogCount;
    if (rdAddr == ADDR_W'(A_CLK_SEL))     rdData = CNT_W'(extSel);
    for (int i = 0; i < NUM_TMR; i++) begin
      if (rdAddr == ADDR_W'(A_TMR_BASE + TMR_STRIDE * i + OFF_RELOAD)) rdData = tmrReload[i];
      if (rdAddr == ADDR_W'(A_TMR_BASE + TMR_STRIDE * i + OFF_COUNT))  rdData = tmrCount[i];
      if (rdAddr == ADDR_W'(A_TMR_BASE + TMR_STRIDE * i + OFF_CTRL))   rdData = CNT_W'(tmrCtrl[i]);
    end
  end
endmodule

// File: tb/tickTimerUnit_test.sv
module tickTimerUnit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] C_EN = 32'h1, C_AUTO = 32'h2, C_LOAD = 32'h4,
                          C_TRIG = 32'h8, C_CLR = 32'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extClk = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [1:0]  irq, trigOut;
  logic        wdogN;

  longint cyc = 0;
  int     nChecks = 0;
  int     nFail = 0;
  bit     done = 1'b0;

  tickTimerUnit uut (
    .clk(clk), .rstN(rstN), .extClk(extClk), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq),
    .trigOut(trigOut), .wdogN(wdogN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, output longint e);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
    e = cyc;
  endtask

  task automatic waitTo(input longint e);
    while (cyc < e) begin @(posedge clk); #1; end
    #4;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rdAddr = 4'(a); #1; v = rdData;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    longint e, e0, d;
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #4 rstN = 1'b1;
    @(posedge clk); #5;

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 trigOut", 32'(trigOut), 0);
    check("R1 wdogN", 32'(wdogN), 1);
    foreach (v[i]) begin end
    for (int a = 0; a <= 10; a++) begin
      if (a == 1 || a == 8 || a == 9) continue;
      rd(a, v);
      check($sformatf("R1 reg%0d", a), v, 0);
    end

    wr(8, 32'h00FF_FFFF, e);

    // R2 R3 R4 R6: one-shot sweep over prescaler and load values on timer 0
    foreach (v[i]) begin end
    for (int pi = 0; pi < 3; pi++) begin
      for (int ni = 0; ni < 3; ni++) begin
        int p, n;
        longint k;
        p = (pi == 0) ? 0 : (pi == 1) ? 1 : 3;
        n = (ni == 0) ? 0 : (ni == 1) ? 1 : 4;
        k = longint'((n + 1) * (p + 1));
        wr(0, 1023, e);
        wr(2, 32'(n), e);
        wr(4, C_EN | C_LOAD | C_TRIG | C_CLR, e);
        wr(0, 32'(p), e0);
        waitTo(e0 + k - 1);
        check($sformatf("R2 irq early p%0d n%0d", p, n), 32'(irq[0]), 0);
        waitTo(e0 + k);
        check($sformatf("R4 irq at underflow p%0d n%0d", p, n), 32'(irq[0]), 1);
        check($sformatf("R6 trig start p%0d n%0d", p, n), 32'(trigOut[0]), 1);
        waitTo(e0 + k + 7);
        check($sformatf("R6 trig last p%0d n%0d", p, n), 32'(trigOut[0]), 1);
        waitTo(e0 + k + 8);
        check($sformatf("R6 trig end p%0d n%0d", p, n), 32'(trigOut[0]), 0);
        rd(4, v);
        check($sformatf("R4 one-shot stopped p%0d n%0d", p, n), v & 32'h3, 0);
        rd(3, v);
        check($sformatf("R4 count held p%0d n%0d", p, n), v, 0);
      end
    end

    // R5 clear flag
    wr(4, C_CLR, e);
    check("R5 irq cleared", 32'(irq[0]), 0);

    // R4 auto-reload on timer 1: p=2, n=3, period 12
    wr(0, 1023, e);
    wr(5, 3, e);
    wr(7, C_EN | C_AUTO | C_LOAD, e);
    wr(0, 2, e0);
    waitTo(e0 + 12);
    check("R4 auto first irq", 32'(irq[1]), 1);
    rd(6, v);
    check("R4 auto reload count", v, 3);
    wr(7, C_EN | C_AUTO | C_CLR, e);
    check("R5 auto irq cleared", 32'(irq[1]), 0);
    waitTo(e0 + 23);
    check("R4 auto second early", 32'(irq[1]), 0);
    waitTo(e0 + 24);
    check("R4 auto second irq", 32'(irq[1]), 1);
    wr(7, C_CLR, e);

    // R7 retrigger: underflow every cycle keeps the pulse high
    wr(0, 1023, e);
    wr(5, 0, e);
    wr(7, C_EN | C_AUTO | C_LOAD | C_TRIG, e);
    wr(0, 0, e0);
    waitTo(e0 + 20);
    check("R7 trig held by retrigger", 32'(trigOut[1]), 1);
    wr(7, C_CLR, d);
    waitTo(d + 7);
    check("R7 trig after last fire", 32'(trigOut[1]), 1);
    waitTo(d + 8);
    check("R7 trig end after last fire", 32'(trigOut[1]), 0);

    // R8 R9 watchdog expiry with p=1, w=5
    wr(0, 1023, e);
    wr(0, 1, e0);
    wr(8, 5, e);
    waitTo(e0 + 11);
    check("R8 wdog before expiry", 32'(wdogN), 1);
    waitTo(e0 + 12);
    check("R8 wdog expired", 32'(wdogN), 0);
    waitTo(e0 + 30);
    check("R8 wdog stays low", 32'(wdogN), 0);
    wr(8, 32'h00FF_FFFF, e);
    waitTo(e);
    check("R9 wdog restart", 32'(wdogN), 1);

    // R10 external clock source
    wr(0, 0, e);
    wr(10, 1, e);
    wr(2, 2, e);
    wr(4, C_EN | C_LOAD | C_CLR, e);
    repeat (40) @(posedge clk);
    #5;
    rd(3, v);
    check("R10 system clock ignored", v, 2);
    check("R10 no irq without edges", 32'(irq[0]), 0);
    for (int pn = 1; pn <= 3; pn++) begin
      @(negedge clk); extClk = 1'b1;
      repeat (3) @(negedge clk);
      extClk = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      if (pn < 3) begin
        rd(3, v);
        check($sformatf("R10 R3 count after edge %0d", pn), v, 32'(2 - pn));
        check($sformatf("R10 irq after edge %0d", pn), 32'(irq[0]), 0);
      end else begin
        check("R10 irq after third edge", 32'(irq[0]), 1);
      end
    end
    wr(10, 0, e);

    done = 1'b1;
    finishRun();
  end
endmodule